// File: doc/BRIEF.md
# I2C Serial Clock Phase Timer

This block sets the pace of the serial clock for an I2C bus master. One divider word, written as a single value, holds two independent divisors: one for the time the clock spends low and one for the time it spends high. Each divisor unit is a fixed number of input clock cycles (a sub-step count, eight by default). So one full clock period takes `SUB_STEPS × (low + high)` input cycles. Software usually loads the same value into both halves, which gives a duty cycle near fifty percent. That value is the rounded-up half of the rounded-up ratio `fclk / (8·fscl)`, for target rates from 10 kHz to 400 kHz.

While the run enable is high, the block drives the clock through alternating low and high phases. It also gives the bus engine single-cycle strobes: one at the first cycle of each phase, one at the middle of each low phase (the only safe point to change the data line), and one at the middle of each high phase (where data is sampled). A divider write never shortens a period in progress. Both divisors are captured only when a low phase begins. When the enable is low, the clock stays released (high) and no strobes are produced.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `scl_o` is 1, all four strobes are 0 and `div_rdata` equals `RESET_DIV` (0 by default).
- R2: A cycle with `div_wr` high stores `div_wdata`, and it reads back on `div_rdata` from the next cycle. The low divisor is bits `DIV_W-1:0` and the high divisor is bits `2*DIV_W-1:DIV_W`.
- R3: Each low phase (`scl_o` = 0) lasts exactly `SUB_STEPS × low` input cycles.
- R4: Each high phase inside a run lasts exactly `SUB_STEPS × high` cycles, so a full period is `SUB_STEPS × (low + high)` cycles.
- R5: A divisor field of zero behaves exactly like a field of one.
- R6: Divisors are captured only at the first cycle of a low phase. A write during a period leaves that period's remaining low and high lengths unchanged and applies from the next low phase.
- R7: `sda_change` pulses for one cycle, while `scl_o` is 0, exactly `SUB_STEPS/2 × low` cycles after the low phase starts.
- R8: `sda_sample` pulses for one cycle, while `scl_o` is 1, exactly `SUB_STEPS/2 × high` cycles after the high phase starts.
- R9: A cycle with `run_en` low makes `scl_o` 1 from the next cycle on. While `run_en` stays low, no strobe occurs.
- R10: `low_begin` pulses in the first cycle where `scl_o` is 0, and `high_begin` pulses in the first cycle where `scl_o` is 1 after a low phase. When `run_en` rises, the first low phase starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Engine active; low releases the clock |
| div_wr | input | 1 | Write strobe for the divider word |
| div_wdata | input | 2*DIV_W | Divider word: high divisor in the upper half, low divisor in the lower half |
| div_rdata | output | 2*DIV_W | Stored divider word |
| scl_o | output | 1 | Serial clock level, 1 = released |
| low_begin | output | 1 | First cycle of a low phase |
| high_begin | output | 1 | First cycle of a high phase |
| sda_change | output | 1 | Midpoint of the low phase, where the data line may change |
| sda_sample | output | 1 | Midpoint of the high phase, where data is sampled |

## Verification
The bench builds the block with `DIV_W = 8` and the default `SUB_STEPS = 8`. This makes the largest divisor pair (255, 255) one 4080-cycle period, short enough to run in full next to the small, zero and odd values. Odd divisors put the midpoint strobes half a unit into a phase, and zero fields take the clamp path. A write during a running period shows whether the old lengths still finish before the new ones apply. The run is also dropped in the middle of a low phase, which shows the clock being released early with no further strobes.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

endpackage

// File: rtl/scl_div_reg.sv
module scl_div_reg #(
    parameter int DIV_W     = 16,
    parameter int RESET_DIV = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [2*DIV_W-1:0] wdata,
    input  logic               load,
    output logic [2*DIV_W-1:0] word_o,
    output logic [DIV_W-1:0]   low_o,
    output logic [DIV_W-1:0]   high_o
);
    localparam int WORD_W = 2 * DIV_W;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [DIV_W-1:0]  low;
        logic [DIV_W-1:0]  high;
    } div_state_t;

    div_state_t s_d, s_q;

    logic [DIV_W-1:0] fld_low, fld_high;

    always_comb begin
        s_d      = s_q;
        fld_low  = s_q.word[DIV_W-1:0];
        fld_high = s_q.word[WORD_W-1:DIV_W];
        if (wr) begin
            s_d.word = wdata;
        end
        if (load) begin
            // a zero field counts as one unit
            s_d.low  = (fld_low  == '0) ? DIV_W'(1) : fld_low;
            s_d.high = (fld_high == '0) ? DIV_W'(1) : fld_high;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.word <= WORD_W'(RESET_DIV);
            s_q.low  <= DIV_W'(1);
            s_q.high <= DIV_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o = s_q.word;
    assign low_o  = s_q.low;
    assign high_o = s_q.high;

    assert_word_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (word_o == $past(wdata)));

    assert_capture_only_at_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(low_o) && $stable(high_o)));

endmodule

// File: rtl/scl_substep.sv
module scl_substep #(
    parameter int SUB_STEPS = 8,
    localparam int SUB_W    = (SUB_STEPS > 1) ? $clog2(SUB_STEPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [SUB_W-1:0] sub_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [SUB_W-1:0] sub;
    } sub_state_t;

    sub_state_t s_d, s_q;

    logic at_last;

    always_comb begin
        s_d     = s_q;
        at_last = (s_q.sub == SUB_W'(SUB_STEPS - 1));
        if (!run) begin
            s_d.sub = '0;
        end else if (at_last) begin
            s_d.sub = '0;
        end else begin
            s_d.sub = s_q.sub + SUB_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.sub <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sub_o  = s_q.sub;
    assign wrap_o = run && at_last;

    assert_idle_holds_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> (sub_o == '0));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int SUB_STEPS = 8,
    localparam int SUB_W    = (SUB_STEPS > 1) ? $clog2(SUB_STEPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] low_div,
    input  logic [DIV_W-1:0] high_div,
    input  logic [SUB_W-1:0] sub,
    input  logic             wrap,
    output logic             active_o,
    output logic             load_o,
    output logic             scl_o,
    output logic             low_begin_o,
    output logic             high_begin_o,
    output logic             mid_low_o,
    output logic             mid_high_o
);
    localparam logic [SUB_W-1:0] HALF_SUB = SUB_W'(SUB_STEPS / 2);

    typedef struct packed {
        phase_e           ph;
        logic [DIV_W-1:0] unit;
        logic             scl;
    } fsm_state_t;

    fsm_state_t s_d, s_q;

    logic [DIV_W-1:0] cur_div;
    logic             last_unit;
    logic             load;
    logic             at_first;
    logic             at_mid;
    logic [SUB_W-1:0] mid_sub;

    always_comb begin
        s_d       = s_q;
        load      = 1'b0;
        cur_div   = (s_q.ph == PH_HIGH) ? high_div : low_div;
        last_unit = (s_q.unit == (cur_div - DIV_W'(1)));
        unique case (s_q.ph)
            PH_IDLE: begin
                if (en) begin
                    s_d.ph   = PH_LOW;
                    s_d.unit = '0;
                    load     = 1'b1;
                end
            end
            PH_LOW: begin
                if (!en) begin
                    s_d.ph   = PH_IDLE;
                    s_d.unit = '0;
                end else if (wrap) begin
                    if (last_unit) begin
                        s_d.ph   = PH_HIGH;
                        s_d.unit = '0;
                    end else begin
                        s_d.unit = s_q.unit + DIV_W'(1);
                    end
                end
            end
            PH_HIGH: begin
                if (!en) begin
                    s_d.ph   = PH_IDLE;
                    s_d.unit = '0;
                end else if (wrap) begin
                    if (last_unit) begin
                        s_d.ph   = PH_LOW;
                        s_d.unit = '0;
                        load     = 1'b1;
                    end else begin
                        s_d.unit = s_q.unit + DIV_W'(1);
                    end
                end
            end
            default: begin
                s_d.ph   = PH_IDLE;
                s_d.unit = '0;
            end
        endcase
        s_d.scl = (s_d.ph != PH_LOW);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph   <= PH_IDLE;
            s_q.unit <= '0;
            s_q.scl  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // midpoint = SUB_STEPS/2 * div cycles = unit div>>1, plus half a unit when div is odd
    always_comb begin
        mid_sub  = cur_div[0] ? HALF_SUB : '0;
        at_first = (s_q.unit == '0) && (sub == '0);
        at_mid   = (s_q.unit == (cur_div >> 1)) && (sub == mid_sub);
    end

    assign active_o     = (s_q.ph != PH_IDLE);
    assign load_o       = load;
    assign scl_o        = s_q.scl;
    assign low_begin_o  = (s_q.ph == PH_LOW)  && at_first;
    assign high_begin_o = (s_q.ph == PH_HIGH) && at_first;
    assign mid_low_o    = (s_q.ph == PH_LOW)  && at_mid;
    assign mid_high_o   = (s_q.ph == PH_HIGH) && at_mid;

    assert_low_unit_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_LOW) |-> (s_q.unit < low_div));

    assert_high_unit_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_HIGH) |-> (s_q.unit < high_div));

    assert_phase_starts_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_IDLE && $past(s_q.ph) != s_q.ph) |-> (sub == '0));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
    parameter int DIV_W     = 16,
    parameter int SUB_STEPS = 8,
    parameter int RESET_DIV = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               div_wr,
    input  logic [2*DIV_W-1:0] div_wdata,
    output logic [2*DIV_W-1:0] div_rdata,
    output logic               scl_o,
    output logic               low_begin,
    output logic               high_begin,
    output logic               sda_change,
    output logic               sda_sample
);
    localparam int SUB_W = (SUB_STEPS > 1) ? $clog2(SUB_STEPS) : 1;

    logic [DIV_W-1:0] low_div, high_div;
    logic [SUB_W-1:0] sub;
    logic             wrap;
    logic             active;
    logic             load;

    scl_div_reg #(
        .DIV_W     (DIV_W),
        .RESET_DIV (RESET_DIV)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (div_wr),
        .wdata  (div_wdata),
        .load   (load),
        .word_o (div_rdata),
        .low_o  (low_div),
        .high_o (high_div)
    );

    scl_substep #(
        .SUB_STEPS (SUB_STEPS)
    ) u_sub (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (active),
        .sub_o  (sub),
        .wrap_o (wrap)
    );

    scl_phase_fsm #(
        .DIV_W     (DIV_W),
        .SUB_STEPS (SUB_STEPS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (run_en),
        .low_div      (low_div),
        .high_div     (high_div),
        .sub          (sub),
        .wrap         (wrap),
        .active_o     (active),
        .load_o       (load),
        .scl_o        (scl_o),
        .low_begin_o  (low_begin),
        .high_begin_o (high_begin),
        .mid_low_o    (sda_change),
        .mid_high_o   (sda_sample)
    );

    assert_release_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> scl_o);

    assert_fall_marks_low_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> low_begin);

    assert_rise_marks_high_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_o) && run_en && $past(run_en)) |-> high_begin);

    assert_change_while_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |-> !scl_o);

    assert_sample_while_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample |-> scl_o);

    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_begin, high_begin, sda_change, sda_sample}));

endmodule

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;

    localparam int DW  = 8;
    localparam int SUB = 8;
    localparam int HS  = SUB / 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            run_en = 1'b0;
    logic            div_wr = 1'b0;
    logic [2*DW-1:0] div_wdata = '0;
    logic [2*DW-1:0] div_rdata;
    logic            scl_o, low_begin, high_begin, sda_change, sda_sample;

    always #2.5 clk = ~clk;   // 200 MHz

    scl_timing_gen #(.DIV_W(DW), .SUB_STEPS(SUB)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .div_wr(div_wr), .div_wdata(div_wdata), .div_rdata(div_rdata),
        .scl_o(scl_o), .low_begin(low_begin), .high_begin(high_begin),
        .sda_change(sda_change), .sda_sample(sda_sample)
    );

    // kinds: 0 low start, 1 data change, 2 high start, 3 sample
    typedef struct {
        int    kind;
        int    delta;   // cycles since previous strobe, -1 = unchecked
        string req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   last_cyc = 0;
    int   act_kind;
    exp_t e;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: pop one expected item per strobe
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (low_begin || high_begin || sda_change || sda_sample) begin
                act_kind = low_begin ? 0 : sda_change ? 1 : high_begin ? 2 : 3;
                if (q.size() == 0) begin
                    check(1'b0, "R9 unexpected strobe", act_kind, -1);
                end else begin
                    e = q.pop_front();
                    check(act_kind == e.kind, {e.req, " strobe kind"}, act_kind, e.kind);
                    if (e.delta >= 0)
                        check(cyc - last_cyc == e.delta, {e.req, " spacing"}, cyc - last_cyc, e.delta);
                    check(scl_o == (e.kind >= 2), {e.req, " scl level"}, int'(scl_o), int'(e.kind >= 2));
                end
                last_cyc = cyc;
            end
        end
    end

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic push(input int kind, input int delta, input string req);
        exp_t x;
        x.kind = kind; x.delta = delta; x.req = req;
        q.push_back(x);
    endtask

    // one period: lb_delta is spacing from the previous sample strobe
    task automatic push_period(input int l, input int h, input int lb_delta);
        push(0, lb_delta, "R10");
        push(1, HS * eff(l), "R7");
        push(2, HS * eff(l), "R3");
        push(3, HS * eff(h), "R8");
    endtask

    task automatic write_div(input int l, input int h);
        div_wr    = 1'b1;
        div_wdata = {DW'(h), DW'(l)};
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic drain_and_stop();
        while (q.size() != 0) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(scl_o == 1'b1, "R9 scl after stop", int'(scl_o), 1);
        repeat (40) @(negedge clk);
    endtask

    task automatic run_periods(input int l, input int h, input int n);
        write_div(l, h);
        for (int i = 0; i < n; i++)
            push_period(l, h, (i == 0) ? -1 : HS * eff(h));
        run_en = 1'b1;
        drain_and_stop();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(scl_o == 1'b1, "R1 scl", int'(scl_o), 1);
        check({low_begin, high_begin, sda_change, sda_sample} == 4'b0, "R1 strobes",
              int'({low_begin, high_begin, sda_change, sda_sample}), 0);
        check(div_rdata == '0, "R1 div word", int'(div_rdata), 0);

        // R2 write and field positions: low in bits 7:0, high in 15:8
        write_div(2, 5);
        check(div_rdata == 16'h0502, "R2 readback", int'(div_rdata), 16'h0502);

        // R3 R4 symmetric and asymmetric
        run_periods(3, 3, 3);
        run_periods(1, 5, 2);
        run_periods(2, 5, 2);
        // R7 R8 odd divisors give half-unit midpoints
        run_periods(5, 7, 2);
        // R5 zero fields behave as one
        run_periods(0, 0, 2);
        run_periods(0, 2, 2);

        // R6 write during a period applies only from the next low phase
        write_div(2, 3);
        push_period(2, 3, -1);
        push_period(4, 1, HS * 3);
        push_period(4, 1, HS * 1);
        run_en = 1'b1;
        repeat (4) @(negedge clk);
        write_div(4, 1);
        check(div_rdata == 16'h0104, "R6 new word stored", int'(div_rdata), 16'h0104);
        drain_and_stop();

        // R3 R4 largest divisors
        run_periods(255, 255, 1);

        // R9 drop the run in the middle of a low phase
        write_div(10, 10);
        push(0, -1, "R10");
        run_en = 1'b1;
        repeat (6) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(scl_o == 1'b1, "R9 released mid low", int'(scl_o), 1);
        repeat (200) begin
            @(negedge clk);
            if (scl_o !== 1'b1) check(1'b0, "R9 scl held", int'(scl_o), 1);
        end
        check(q.size() == 0, "R10 start strobe seen", q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule